// File: doc/BRIEF.md
# Delay-Compensated Unipolar Sine PWM Generator

This block drives the four switches of a full-bridge inverter with unipolar sinusoidal PWM. It uses symmetric regular sampling. A phase register moves forward by a programmable step once per carrier period. A computed half-wave sine table, scaled by a modulation index, turns that phase into a reference sample. The sample is taken once at the carrier boundary and held for the whole period. It sets how long the switch conducts, and the pulse is centred on the middle of the period.

Real power switches turn on late and turn off late, so the charge delivered to the load differs from the ideal. To correct this, software measures six edge instants: three on the turn-on transition and three on the turn-off transition. From these the block forms a signed correction in hardware. The correction is added to the ideal on-time, and the sum is clamped to the carrier period. The sign of the reference sample chooses which bridge leg is modulated. Every programmable input is captured only at a carrier boundary.

Top module: `spwm_gen`

## Requirements
- R1: While reset is asserted, all four gate outputs are low. After release, the first clock edge starts carrier period 0.
- R2: A carrier period lasts `carrier_period` clocks, sampled at each period start. Values below 2 count as 2. The count runs 0 to T-1.
- R3: The 16-bit phase is 0 in period 0 and grows by `freq_word` each period. Bit 15 is the reference sign (1 = negative half). Bits 14:9 give the table index i (0..63). The table magnitude is floor(4095·16·i·(64−i) / (5·4096 − 4·i·(64−i))).
- R4: The scaled sample is s = floor(mag · `mod_index` / 512), where `mod_index` is unsigned with 9 fraction bits. The ideal on-time is floor(T · s / 4096).
- R5: The correction doubled is D = `off_edge_b` + `off_edge_c` + 2·`on_edge_a` − `on_edge_b` − `on_edge_c` − 2·`off_edge_a`. The applied on-time is floor((2·ideal + D)/2).
- R6: The applied on-time is clamped to 0..T. A value of 0 gives no high pulse in that period. A value of T keeps the modulated high-side switch on for the whole period.
- R7: With on-time N in a period of T clocks, the modulated high-side switch is on for counts floor((T−N)/2) through floor((T−N)/2)+N−1.
- R8: During a positive sample, leg A is modulated: its high side follows the pulse and its low side is the complement. Leg B keeps its low side on and its high side off. During a negative sample the two legs swap roles.
- R9: The high and low outputs of the same leg are never high in the same cycle.
- R10: Changes to `carrier_period`, `freq_word`, `mod_index` or the edge inputs during a period leave that period's pulse unchanged. They take effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_period | input | 16 | Carrier period in clocks |
| freq_word | input | 16 | Phase step per carrier period |
| mod_index | input | 10 | Modulation index, 9 fraction bits |
| on_edge_a | input | 12 | First turn-on edge instant, clocks |
| on_edge_b | input | 12 | Second turn-on edge instant, clocks |
| on_edge_c | input | 12 | Third turn-on edge instant, clocks |
| off_edge_a | input | 12 | First turn-off edge instant, clocks |
| off_edge_b | input | 12 | Second turn-off edge instant, clocks |
| off_edge_c | input | 12 | Third turn-off edge instant, clocks |
| leg_a_high | output | 1 | Leg A high-side gate |
| leg_a_low | output | 1 | Leg A low-side gate |
| leg_b_high | output | 1 | Leg B high-side gate |
| leg_b_low | output | 1 | Leg B low-side gate |

## Verification
The gate outputs are built only from registered state, so an input captured at a period's last clock edge shows up in the gates one cycle later, at count 0 of the next period, and nowhere earlier. The bench's behavioural model updates at the same edges that the design uses and captures inputs at the same period boundaries. It is compared with the four gates at every falling edge, half a cycle after each update. The directed pulse counts begin at the first falling edge after reset release, which is count 0 of period 0. Each counting window therefore covers whole periods, with the pulse offset and width known in advance.

// File: rtl/spwm_pkg.sv
// Shared helpers for the sine PWM generator.
// Assumes the half-wave table length is a power of two.
package spwm_pkg;

    // Rational approximation of sin(pi*idx/half_len), scaled to amp.
    function automatic int sine_mag(int idx, int half_len, int amp);
        longint p;
        longint num;
        longint den;
        p   = longint'(idx) * longint'(half_len - idx);
        num = longint'(amp) * 16 * p;
        den = 5 * longint'(half_len) * longint'(half_len) - 4 * p;
        return int'(num / den);
    endfunction

endpackage

// File: rtl/spwm_sine_ref.sv
// Turns a phase word into a sign and a modulation-scaled magnitude.
// Assumes PH_W > AW + 1; the table is computed at elaboration.
module spwm_sine_ref #(
    parameter int PH_W  = 16,
    parameter int AW    = 6,
    parameter int MAG_W = 12,
    parameter int MI_W  = 10
) (
    input  logic [PH_W-1:0]  phase,
    input  logic [MI_W-1:0]  mod_index,
    output logic             negative,
    output logic [MAG_W:0]   scaled
);
    localparam int H    = 1 << AW;
    localparam int AMP  = (1 << MAG_W) - 1;
    localparam int PR_W = MAG_W + MI_W;

    logic [MAG_W-1:0] lut [H];
    logic [AW-1:0]    idx;
    logic [PR_W-1:0]  prod;

    // One table entry per half-wave index.
    for (genvar g = 0; g < H; g++) begin : g_lut
        assign lut[g] = MAG_W'(spwm_pkg::sine_mag(g, H, AMP));
    end

    // Look up the magnitude and apply the modulation index.
    always_comb begin
        negative = phase[PH_W-1];
        idx      = AW'(phase >> (PH_W - 1 - AW));
        prod     = PR_W'(lut[idx]) * PR_W'(mod_index);
        scaled   = (MAG_W+1)'(prod >> (MI_W - 1));
    end
endmodule

// File: rtl/spwm_delay_comp.sv
// Computes the ideal on-time, adds the switching-delay correction
// and clamps the result to 0..period. Pure combinational.
module spwm_delay_comp #(
    parameter int PER_W = 16,
    parameter int MAG_W = 12,
    parameter int ET_W  = 12
) (
    input  logic [PER_W-1:0] period,
    input  logic [MAG_W:0]   scaled,
    input  logic [ET_W-1:0]  on_e0,
    input  logic [ET_W-1:0]  on_e1,
    input  logic [ET_W-1:0]  on_e2,
    input  logic [ET_W-1:0]  off_e0,
    input  logic [ET_W-1:0]  off_e1,
    input  logic [ET_W-1:0]  off_e2,
    output logic [PER_W-1:0] on_time
);
    localparam int SC_W = MAG_W + 1;
    localparam int PW2  = PER_W + SC_W;
    localparam int SW   = ((PER_W > ET_W) ? PER_W : ET_W) + 4;

    logic [PW2-1:0]        prod;
    logic [PER_W:0]        raw;
    logic signed [SW-1:0]  sum2;
    logic signed [SW-1:0]  half;

    // Ideal time, doubled correction, floor halving, clamp.
    always_comb begin
        prod = PW2'(period) * PW2'(scaled);
        raw  = (PER_W+1)'(prod >> MAG_W);
        sum2 = ($signed(SW'(raw)) <<< 1)
             + $signed(SW'(off_e1)) + $signed(SW'(off_e2))
             + ($signed(SW'(on_e0)) <<< 1)
             - $signed(SW'(on_e1)) - $signed(SW'(on_e2))
             - ($signed(SW'(off_e0)) <<< 1);
        half = sum2 >>> 1;
        if (half < 0)
            on_time = '0;
        else if (half > $signed(SW'(period)))
            on_time = period;
        else
            on_time = PER_W'(half);
    end
endmodule

// File: rtl/spwm_carrier.sv
// Carrier period counter. Marks the last clock of each period and
// captures the next period length there. Assumes synchronous reset.
module spwm_carrier #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_in,
    output logic             wrap,
    output logic [PER_W-1:0] count,
    output logic [PER_W-1:0] period_q,
    output logic [PER_W-1:0] period_next
);
    // Enforce the minimum period and detect the end of a period.
    always_comb begin
        period_next = (period_in < PER_W'(2)) ? PER_W'(2) : period_in;
        wrap        = ((PER_W+1)'(count) + (PER_W+1)'(1)) >= (PER_W+1)'(period_q);
    end

    // Advance the count or restart it with the newly captured length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            period_q <= '0;
        end else if (wrap) begin
            count    <= '0;
            period_q <= period_next;
        end else begin
            count    <= count + PER_W'(1);
        end
    end
endmodule

// File: rtl/spwm_gen.sv
// Unipolar sine PWM generator with switching-delay compensation.
// All inputs are captured at a carrier boundary. The gates come from
// registered state only. No dead time is inserted here.
module spwm_gen #(
    parameter int PER_W = 16,
    parameter int PH_W  = 16,
    parameter int AW    = 6,
    parameter int MAG_W = 12,
    parameter int MI_W  = 10,
    parameter int ET_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] carrier_period,
    input  logic [PH_W-1:0]  freq_word,
    input  logic [MI_W-1:0]  mod_index,
    input  logic [ET_W-1:0]  on_edge_a,
    input  logic [ET_W-1:0]  on_edge_b,
    input  logic [ET_W-1:0]  on_edge_c,
    input  logic [ET_W-1:0]  off_edge_a,
    input  logic [ET_W-1:0]  off_edge_b,
    input  logic [ET_W-1:0]  off_edge_c,
    output logic             leg_a_high,
    output logic             leg_a_low,
    output logic             leg_b_high,
    output logic             leg_b_low
);
    logic             wrap_w;
    logic [PER_W-1:0] count_w;
    logic [PER_W-1:0] period_q_w;
    logic [PER_W-1:0] period_next_w;
    logic             neg_w;
    logic [MAG_W:0]   scaled_w;
    logic [PER_W-1:0] on_next_w;

    logic [PH_W-1:0]  phase_q;
    logic [PER_W-1:0] on_q;
    logic             neg_q;
    logic             en_q;

    logic [PER_W-1:0] start_w;
    logic [PER_W:0]   stop_w;
    logic             pulse_w;

    spwm_carrier #(.PER_W(PER_W)) u_carrier (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_in   (carrier_period),
        .wrap        (wrap_w),
        .count       (count_w),
        .period_q    (period_q_w),
        .period_next (period_next_w)
    );

    spwm_sine_ref #(.PH_W(PH_W), .AW(AW), .MAG_W(MAG_W), .MI_W(MI_W)) u_ref (
        .phase     (phase_q),
        .mod_index (mod_index),
        .negative  (neg_w),
        .scaled    (scaled_w)
    );

    spwm_delay_comp #(.PER_W(PER_W), .MAG_W(MAG_W), .ET_W(ET_W)) u_comp (
        .period  (period_next_w),
        .scaled  (scaled_w),
        .on_e0   (on_edge_a),
        .on_e1   (on_edge_b),
        .on_e2   (on_edge_c),
        .off_e0  (off_edge_a),
        .off_e1  (off_edge_b),
        .off_e2  (off_edge_c),
        .on_time (on_next_w)
    );

    // Capture the sample, its polarity and the on-time once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            on_q    <= '0;
            neg_q   <= 1'b0;
            en_q    <= 1'b0;
        end else if (wrap_w) begin
            phase_q <= phase_q + freq_word;
            on_q    <= on_next_w;
            neg_q   <= neg_w;
            en_q    <= 1'b1;
        end
    end

    // Centred pulse window inside the current period.
    always_comb begin
        start_w = (period_q_w - on_q) >> 1;
        stop_w  = (PER_W+1)'(start_w) + (PER_W+1)'(on_q);
        pulse_w = en_q && (count_w >= start_w) && ((PER_W+1)'(count_w) < stop_w);
    end

    // Leg selection by polarity; each leg drives complementary outputs.
    always_comb begin
        leg_a_high = en_q && !neg_q && pulse_w;
        leg_a_low  = en_q && (neg_q || !pulse_w);
        leg_b_high = en_q && neg_q && pulse_w;
        leg_b_low  = en_q && (!neg_q || !pulse_w);
    end
endmodule

// File: rtl/spwm_gen_chk.sv
// Property checker for spwm_gen, attached through bind below.
module spwm_gen_chk #(
    parameter int PER_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             leg_a_high,
    input logic             leg_a_low,
    input logic             leg_b_high,
    input logic             leg_b_low,
    input logic             en_q,
    input logic             neg_q,
    input logic             wrap_w,
    input logic [PER_W-1:0] on_q,
    input logic [PER_W-1:0] count_w,
    input logic [PER_W-1:0] period_q_w
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !(leg_a_high || leg_a_low || leg_b_high || leg_b_low));

    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> (count_w < period_q_w));

    a_r6_zero_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && on_q == '0) |-> (!leg_a_high && !leg_b_high));

    a_r6_full_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && on_q == period_q_w) |-> (leg_a_high || leg_b_high));

    a_r8_pos_leg_b: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !neg_q) |-> (leg_b_low && !leg_b_high));

    a_r8_neg_leg_a: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && neg_q) |-> (leg_a_low && !leg_a_high));

    a_r9_leg_a_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg_a_high && leg_a_low));

    a_r9_leg_b_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg_b_high && leg_b_low));

    a_r10_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_w |=> ($stable(on_q) && $stable(period_q_w) && $stable(neg_q)));
endmodule

bind spwm_gen spwm_gen_chk #(.PER_W(PER_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .leg_a_high (leg_a_high),
    .leg_a_low  (leg_a_low),
    .leg_b_high (leg_b_high),
    .leg_b_low  (leg_b_low),
    .en_q       (en_q),
    .neg_q      (neg_q),
    .wrap_w     (wrap_w),
    .on_q       (on_q),
    .count_w    (count_w),
    .period_q_w (period_q_w)
);

// File: tb/tb_spwm_gen.sv
// Self-checking bench: behavioural model compared every cycle,
// plus directed pulse counts over whole carrier periods.
module tb_spwm_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] carrier_period = 16'd100;
    logic [15:0] freq_word = 16'h4000;
    logic [9:0]  mod_index = 10'd512;
    logic [11:0] on_edge_a = '0, on_edge_b = '0, on_edge_c = '0;
    logic [11:0] off_edge_a = '0, off_edge_b = '0, off_edge_c = '0;
    logic        leg_a_high, leg_a_low, leg_b_high, leg_b_low;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Model state.
    int m_en = 0, m_cnt = 0, m_per = 0, m_on = 0, m_neg = 0, m_phase = 0;

    always #2 clk = ~clk;

    spwm_gen dut (
        .clk(clk), .rst_n(rst_n), .carrier_period(carrier_period),
        .freq_word(freq_word), .mod_index(mod_index),
        .on_edge_a(on_edge_a), .on_edge_b(on_edge_b), .on_edge_c(on_edge_c),
        .off_edge_a(off_edge_a), .off_edge_b(off_edge_b), .off_edge_c(off_edge_c),
        .leg_a_high(leg_a_high), .leg_a_low(leg_a_low),
        .leg_b_high(leg_b_high), .leg_b_low(leg_b_low)
    );

    function automatic int tbl(int i);
        longint p;
        p = longint'(i) * (64 - i);
        return int'((longint'(4095) * 16 * p) / (5 * 4096 - 4 * p));
    endfunction

    task automatic check_eq(string tag, int got, int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Model update at the same edge as the design.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_en = 0; m_cnt = 0; m_per = 0; m_on = 0; m_neg = 0; m_phase = 0;
        end else if (m_cnt + 1 >= m_per) begin
            int idx, sc, raw, d2, h;
            m_per = (carrier_period < 2) ? 2 : int'(carrier_period);
            idx   = (m_phase >> 9) & 63;
            m_neg = (m_phase >> 15) & 1;
            sc    = (tbl(idx) * int'(mod_index)) >> 9;
            raw   = (m_per * sc) >> 12;
            d2    = 2 * raw + int'(off_edge_b) + int'(off_edge_c) + 2 * int'(on_edge_a)
                  - int'(on_edge_b) - int'(on_edge_c) - 2 * int'(off_edge_a);
            h     = d2 >>> 1;
            m_on  = (h < 0) ? 0 : ((h > m_per) ? m_per : h);
            m_phase = (m_phase + int'(freq_word)) & 16'hFFFF;
            m_cnt = 0;
            m_en  = 1;
        end else begin
            m_cnt++;
        end
    end

    // Cycle-by-cycle comparison, half a cycle after each update.
    always @(negedge clk) begin
        int st;
        bit p;
        logic [3:0] exp_g, got_g;
        st = (m_per - m_on) >> 1;
        p  = (m_en != 0) && (m_cnt >= st) && (m_cnt < st + m_on);
        exp_g[3] = (m_en != 0) && (m_neg == 0) && p;
        exp_g[2] = (m_en != 0) && ((m_neg != 0) || !p);
        exp_g[1] = (m_en != 0) && (m_neg != 0) && p;
        exp_g[0] = (m_en != 0) && ((m_neg == 0) || !p);
        got_g = {leg_a_high, leg_a_low, leg_b_high, leg_b_low};
        checks++;
        if (got_g !== exp_g) begin
            fails++;
            $display("FAIL R1 R2 R3 R4 R5 R7 R8 R10 gates cycle %0d: got %b expected %b",
                     cyc, got_g, exp_g);
        end
        // R9: no leg with both outputs high.
        checks++;
        if ((leg_a_high && leg_a_low) || (leg_b_high && leg_b_low)) begin
            fails++;
            $display("FAIL R9 shoot-through cycle %0d: got %b expected no leg 11", cyc, got_g);
        end
    end

    // Count gate activity over n samples from the next falling edge.
    task automatic count_window(int n, output int ah, output int al,
                                output int bh, output int bl, output int first);
        ah = 0; al = 0; bh = 0; bl = 0; first = -1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (leg_a_high && first < 0) first = k;
            ah += int'(leg_a_high); al += int'(leg_a_low);
            bh += int'(leg_b_high); bl += int'(leg_b_low);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_edges(int a, int b, int c, int d, int e, int f);
        on_edge_a = 12'(a); on_edge_b = 12'(b); on_edge_c = 12'(c);
        off_edge_a = 12'(d); off_edge_b = 12'(e); off_edge_c = 12'(f);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int ah, al, bh, bl, first;
        repeat (5) @(negedge clk);
        // R1: reset state.
        check_eq("R1 gates in reset", int'({leg_a_high, leg_a_low, leg_b_high, leg_b_low}), 0);
        rst_n = 1'b1;

        // R3 R4 R8: quarter-turn phase steps, T=100, index 1.0.
        count_window(400, ah, al, bh, bl, first);
        check_eq("R3 R4 leg A high count", ah, 99);
        check_eq("R3 R8 leg B high count", bh, 99);
        check_eq("R8 leg A low count", al, 301);
        check_eq("R8 leg B low count", bl, 301);

        // R5 R7: correction only, D=20 -> on 10 in T=40.
        freq_word = 16'h0000; mod_index = 10'd0; carrier_period = 16'd40;
        set_edges(10, 0, 0, 0, 0, 0);
        do_reset();
        count_window(120, ah, al, bh, bl, first);
        check_eq("R5 corrected width x3", ah, 30);
        check_eq("R7 pulse start offset", first, 15);

        // R6: negative odd correction floors to -2, clamps to 0.
        set_edges(0, 3, 0, 0, 0, 0);
        do_reset();
        count_window(120, ah, al, bh, bl, first);
        check_eq("R6 zero on-time high count", ah, 0);
        check_eq("R6 zero on-time low count", al, 120);

        // R6: large correction clamps to the full period.
        set_edges(0, 0, 0, 0, 4095, 4095);
        do_reset();
        count_window(120, ah, al, bh, bl, first);
        check_eq("R6 full on-time high count", ah, 120);

        // R2: T=30, on 10 -> start offset 10.
        carrier_period = 16'd30;
        set_edges(10, 0, 0, 0, 0, 0);
        do_reset();
        count_window(90, ah, al, bh, bl, first);
        check_eq("R2 width over three periods", ah, 30);
        check_eq("R2 R7 start offset T=30", first, 10);

        // R2: period 1 is treated as 2; on-time clamps to 2.
        carrier_period = 16'd1;
        do_reset();
        count_window(20, ah, al, bh, bl, first);
        check_eq("R2 minimum period full on", ah, 20);

        // R10: changes mid-period only act from the next period.
        carrier_period = 16'd40;
        do_reset();
        count_window(5, ah, al, bh, bl, first);
        set_edges(0, 0, 0, 0, 0, 0);
        carrier_period = 16'd60;
        count_window(35, ah, al, bh, bl, first);
        check_eq("R10 current period unchanged", ah, 10);
        count_window(60, ah, al, bh, bl, first);
        check_eq("R10 next period uses new values", ah, 0);

        // R3 R4 R5: sweeps at several periods, compared every cycle.
        carrier_period = 16'd50; freq_word = 16'h0123; mod_index = 10'd700;
        set_edges(3, 5, 9, 4, 12, 20);
        do_reset();
        repeat (4000) @(negedge clk);
        carrier_period = 16'd2500; freq_word = 16'h1000; mod_index = 10'd1023;
        repeat (20000) @(negedge clk);
        carrier_period = 16'd5000; mod_index = 10'd300;
        set_edges(40, 10, 30, 60, 90, 120);
        repeat (20000) @(negedge clk);
        carrier_period = 16'd12500; freq_word = 16'h2000; mod_index = 10'd512;
        repeat (38000) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule